// File: doc/BRIEF.md
# Timer Channel Clock Gate and Prescaler

This block makes the count-enable strobes for a bank of timer channels, one OS timer channel and one watchdog channel. Every channel picks one of three source strobes: the peripheral clock, the RTC clock or the external clock. It divides the chosen strobe by a power of four and sends out one single-cycle tick per completed division. Each channel can be stopped on its own. Software stops and starts channels through two write-only registers: one sets stop bits and the other clears them. A status register reports which channels are stopped, so software never needs a read-modify-write on a shared word.

All three sources are enable strobes in the single system clock domain. The block sits beside the timer counters, which use `chan_tick` as their count enable. A channel's control register accepts writes only while that channel runs, or while the unit-wide clock enable input is high. Software therefore ungates a channel, or raises the unit enable, before it reprograms the channel.

Top module: `tmr_clk_src`

## Requirements
- R1: After reset every implemented stop bit is 1, every control register reads 0 and no tick is produced. With the default of 8 timers the status register at word address 0 reads 0x000180FF.
- R2: A write to the clear-stop register (word address 2) with 1 in a channel's stop-bit position starts that channel. Bits written as 0 leave their channels unchanged.
- R3: A write to the set-stop register (word address 1) with 1 in a channel's stop-bit position stops that channel. Bits written as 0 leave their channels unchanged. A stopped channel produces no ticks.
- R4: Stop-bit positions are fixed. Timer i uses bit i, the OS timer uses bit 15 and the watchdog uses bit 16. The status register reads 1 for stopped and 0 for running. Unused status bits, the set-stop and clear-stop registers and unmapped addresses read 0. Read data appears on the cycle after the address.
- R5: The control register of channel c sits at word address 8+c. Timers come first, then the OS timer, then the watchdog. Bits [2:0] select the source one-hot: 001 selects the peripheral strobe, 010 the RTC strobe and 100 the external strobe. Bits [5:3] hold the prescale value. Higher bits are ignored on write and read as 0.
- R6: With prescale n, a channel raises `chan_tick[c]` for one cycle on every 4^n-th selected strobe. The tick comes one cycle after that strobe, and n from 0 to 5 gives 1, 4, 16, 64, 256 or 1024. The values 6 and 7 divide by 1024. `chan_tick[i]` is timer i, `chan_tick[NUM_TMR]` is the OS timer and `chan_tick[NUM_TMR+1]` is the watchdog.
- R7: A control-register write to a stopped channel is ignored unless `unit_clk_en` is high in the write cycle.
- R8: A source field of 000, or one with more than one bit set, produces no ticks.
- R9: An accepted control write that changes the prescale value restarts that channel's division count from zero. A selected strobe in that write cycle is discarded. A write that keeps the same prescale value does not disturb the count.
- R10: Stopping a channel clears its division count, so after restart the first tick comes after a full 4^n strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| unit_clk_en | input | 1 | Unit-wide clock enable; lets control writes reach stopped channels |
| reg_addr | input | ADDR_W | Register word address |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the address presented one cycle earlier |
| src_pclk_stb | input | 1 | Peripheral clock source strobe |
| src_rtc_stb | input | 1 | RTC clock source strobe |
| src_ext_stb | input | 1 | External clock source strobe |
| chan_tick | output | NUM_TMR+2 | Per-channel divided tick |

## Verification
The bench targets the corners that go wrong quietly. The OS-timer and watchdog stop bits lie away from the timer bits: a wrong mapping would start the wrong channel. Control writes must be rejected while a channel is stopped: a design that accepts them would retune a gated timer. A source field with two bits set must stay silent: a design that ORs the sources would tick on it. Prescale values 6 and 7 must act as 1024: a design that does not saturate them would wrap to a fast rate. The strobe in the cycle of a prescale change must be dropped: a design that counts it would tick one strobe early. A design that kept the count through a stop and restart would tick early after ungating. A same-value rewrite must leave the count alone: a design that restarts on it would tick late.

// File: rtl/tcs_pkg.sv
`timescale 1ns/1ps
package tcs_pkg;
  // register word addresses
  localparam int ADR_STAT = 0;
  localparam int ADR_SET  = 1;
  localparam int ADR_CLR  = 2;
  localparam int ADR_CTL0 = 8;

  // stop-bit positions of the two special channels
  localparam int POS_OST = 15;
  localparam int POS_WDT = 16;

  // control register field layout
  localparam int SRC_W   = 3;
  localparam int PRE_W   = 3;
  localparam int PRE_LSB = SRC_W;
  localparam int MAX_PRE = 5;

  localparam logic [SRC_W-1:0] SRC_PCLK = 3'b001;
  localparam logic [SRC_W-1:0] SRC_RTC  = 3'b010;
  localparam logic [SRC_W-1:0] SRC_EXT  = 3'b100;

  // channel index to stop-bit position
  function automatic int stop_pos(int ch, int ntmr);
    if (ch < ntmr)
      return ch;
    else if (ch == ntmr)
      return POS_OST;
    else
      return POS_WDT;
  endfunction
endpackage

// File: rtl/tcs_regfile.sv
`timescale 1ns/1ps
module tcs_regfile
  import tcs_pkg::*;
#(
  parameter int NUM_TMR = 8,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  localparam int NCH    = NUM_TMR + 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            unit_clk_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic                            we,
  input  logic [DATA_W-1:0]               wdata,
  output logic [DATA_W-1:0]               rdata,
  output logic [NCH-1:0]                  stop_o,
  output logic [NCH-1:0][SRC_W-1:0]       src_o,
  output logic [NCH-1:0][PRE_W-1:0]       pre_o,
  output logic [NCH-1:0]                  restart_o
);

  logic [NCH-1:0]            stop_q, stop_d;
  logic [NCH-1:0][SRC_W-1:0] src_q, src_d;
  logic [NCH-1:0][PRE_W-1:0] pre_q, pre_d;
  logic [NCH-1:0]            ctl_wr;
  logic [DATA_W-1:0]         rd_d, rd_q;
  logic                      hit_set, hit_clr;
  logic                      unused_wd;

  assign unused_wd = ^wdata;
  assign hit_set   = we && (addr == ADDR_W'(ADR_SET));
  assign hit_clr   = we && (addr == ADDR_W'(ADR_CLR));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int P = stop_pos(c, NUM_TMR);
    logic [PRE_W-1:0] new_pre;

    assign new_pre      = wdata[PRE_LSB +: PRE_W];
    // control write accepted only when running or unit enable is high
    assign ctl_wr[c]    = we && (addr == ADDR_W'(ADR_CTL0 + c)) &&
                          (!stop_q[c] || unit_clk_en);
    assign stop_d[c]    = (hit_set && wdata[P]) ? 1'b1 :
                          (hit_clr && wdata[P]) ? 1'b0 : stop_q[c];
    assign src_d[c]     = ctl_wr[c] ? wdata[SRC_W-1:0] : src_q[c];
    assign pre_d[c]     = ctl_wr[c] ? new_pre : pre_q[c];
    assign restart_o[c] = ctl_wr[c] && (new_pre != pre_q[c]);
  end

  always_comb begin
    rd_d = '0;
    if (addr == ADDR_W'(ADR_STAT)) begin
      for (int c = 0; c < NCH; c++)
        rd_d[stop_pos(c, NUM_TMR)] = stop_q[c];
    end
    for (int c = 0; c < NCH; c++) begin
      if (addr == ADDR_W'(ADR_CTL0 + c))
        rd_d[SRC_W+PRE_W-1:0] = {pre_q[c], src_q[c]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= '1;
      src_q  <= '0;
      pre_q  <= '0;
      rd_q   <= '0;
    end else begin
      stop_q <= stop_d;
      src_q  <= src_d;
      pre_q  <= pre_d;
      rd_q   <= rd_d;
    end
  end

  assign rdata  = rd_q;
  assign stop_o = stop_q;
  assign src_o  = src_q;
  assign pre_o  = pre_q;

endmodule

// File: rtl/tcs_chan_div.sv
`timescale 1ns/1ps
module tcs_chan_div
  import tcs_pkg::*;
#(
  parameter int MAX_N  = MAX_PRE,
  localparam int CNT_W = 2 * MAX_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SRC_W-1:0] src,
  input  logic [PRE_W-1:0] pre,
  input  logic             stb_pclk,
  input  logic             stb_rtc,
  input  logic             stb_ext,
  output logic             tick
);

  logic             sel;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;

  // only an exact one-hot code picks a source
  always_comb begin
    case (src)
      SRC_PCLK: sel = stb_pclk;
      SRC_RTC:  sel = stb_rtc;
      SRC_EXT:  sel = stb_ext;
      default:  sel = 1'b0;
    endcase
  end

  // terminal count 4^n - 1, prescale saturates at MAX_N
  always_comb begin
    if (pre > PRE_W'(MAX_N))
      span = (CNT_W+1)'(1) << (2 * MAX_N);
    else
      span = (CNT_W+1)'(1) << {pre, 1'b0};
    last = CNT_W'(span - (CNT_W+1)'(1));
  end

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (!run || restart) begin
      cnt_d = '0;
    end else if (sel) begin
      if (cnt_q == last) begin
        cnt_d  = '0;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

endmodule

// File: rtl/tmr_clk_src.sv
`timescale 1ns/1ps
module tmr_clk_src
  import tcs_pkg::*;
#(
  parameter int NUM_TMR = 8,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  localparam int NCH    = NUM_TMR + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unit_clk_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              src_pclk_stb,
  input  logic              src_rtc_stb,
  input  logic              src_ext_stb,
  output logic [NCH-1:0]    chan_tick
);

  logic                      rst_meta, rst_n_s;
  logic [NCH-1:0]            stop_vec;
  logic [NCH-1:0][SRC_W-1:0] src_vec;
  logic [NCH-1:0][PRE_W-1:0] pre_vec;
  logic [NCH-1:0]            restart_vec;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  tcs_regfile #(
    .NUM_TMR (NUM_TMR),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .unit_clk_en (unit_clk_en),
    .addr        (reg_addr),
    .we          (reg_we),
    .wdata       (reg_wdata),
    .rdata       (reg_rdata),
    .stop_o      (stop_vec),
    .src_o       (src_vec),
    .pre_o       (pre_vec),
    .restart_o   (restart_vec)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_div
    tcs_chan_div #(
      .MAX_N (MAX_PRE)
    ) u_div (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .run      (!stop_vec[c]),
      .restart  (restart_vec[c]),
      .src      (src_vec[c]),
      .pre      (pre_vec[c]),
      .stb_pclk (src_pclk_stb),
      .stb_rtc  (src_rtc_stb),
      .stb_ext  (src_ext_stb),
      .tick     (chan_tick[c])
    );
  end

endmodule

// File: rtl/tcs_sva.sv
`timescale 1ns/1ps
module tcs_sva
  import tcs_pkg::*;
#(
  parameter int NUM_TMR = 8,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  localparam int NCH    = NUM_TMR + 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      unit_clk_en,
  input logic [ADDR_W-1:0]         reg_addr,
  input logic                      reg_we,
  input logic [DATA_W-1:0]         reg_rdata,
  input logic [NCH-1:0]            chan_tick,
  input logic [NCH-1:0]            stop_vec,
  input logic [NCH-1:0][SRC_W-1:0] src_vec,
  input logic [NCH-1:0][PRE_W-1:0] pre_vec
);

  logic stop_wr;
  assign stop_wr = reg_we && ((reg_addr == ADDR_W'(ADR_SET)) ||
                              (reg_addr == ADDR_W'(ADR_CLR)));

  // R2
  stop_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stop_vec) |-> $past(stop_wr));

  // R4
  strobe_regs_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past((reg_addr == ADDR_W'(ADR_SET)) || (reg_addr == ADDR_W'(ADR_CLR)))
    |-> (reg_rdata == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R3
    no_tick_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_tick[c] |-> $past(!stop_vec[c]));

    // R8
    tick_needs_onehot_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_tick[c] |-> $past($countones(src_vec[c]) == 1));

    // R7
    locked_ctl_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reg_we && (reg_addr == ADDR_W'(ADR_CTL0 + c)) && stop_vec[c] && !unit_clk_en)
      |-> ($stable(src_vec[c]) && $stable(pre_vec[c])));
  end

endmodule

bind tmr_clk_src tcs_sva #(
  .NUM_TMR (NUM_TMR),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W)
) u_sva (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .unit_clk_en (unit_clk_en),
  .reg_addr    (reg_addr),
  .reg_we      (reg_we),
  .reg_rdata   (reg_rdata),
  .chan_tick   (chan_tick),
  .stop_vec    (stop_vec),
  .src_vec     (src_vec),
  .pre_vec     (pre_vec)
);

// File: tb/tmr_clk_src_tb.sv
`timescale 1ns/1ps
module tmr_clk_src_tb;
  localparam int NUM_TMR = 8;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 32;
  localparam int NCH     = NUM_TMR + 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              unit_clk_en;
  logic [ADDR_W-1:0] reg_addr;
  logic              reg_we;
  logic [DATA_W-1:0] reg_wdata;
  logic [DATA_W-1:0] reg_rdata;
  logic              src_pclk_stb, src_rtc_stb, src_ext_stb;
  logic [NCH-1:0]    chan_tick;

  always #10 clk = ~clk;

  tmr_clk_src #(.NUM_TMR(NUM_TMR), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .unit_clk_en(unit_clk_en),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .src_pclk_stb(src_pclk_stb),
    .src_rtc_stb(src_rtc_stb), .src_ext_stb(src_ext_stb),
    .chan_tick(chan_tick)
  );

  int total = 0;
  int bad   = 0;

  // reference model state
  logic       m_stop [NCH];
  logic [2:0] m_src  [NCH];
  logic [2:0] m_pre  [NCH];
  int         m_cnt  [NCH];
  int         obs    [NCH];

  function automatic int bit_of(int c);
    if (c < NUM_TMR) return c;
    if (c == NUM_TMR) return 15;
    return 16;
  endfunction

  function automatic logic [31:0] m_read(logic [ADDR_W-1:0] a);
    logic [31:0] v;
    v = '0;
    if (a == ADDR_W'(0)) begin
      for (int c = 0; c < NCH; c++) v[bit_of(c)] = m_stop[c];
    end
    for (int c = 0; c < NCH; c++)
      if (a == ADDR_W'(8 + c)) v[5:0] = {m_pre[c], m_src[c]};
    return v;
  endfunction

  task automatic check_eq(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic cyc(logic we, logic [ADDR_W-1:0] a, logic [31:0] wd,
                     logic p, logic r, logic e, logic g, string tag);
    logic [NCH-1:0] et;
    logic [31:0]    er;
    logic           run, rs, sel;
    int             n, lim;
    reg_we = we; reg_addr = a; reg_wdata = wd;
    src_pclk_stb = p; src_rtc_stb = r; src_ext_stb = e; unit_clk_en = g;
    er = m_read(a);
    for (int c = 0; c < NCH; c++) begin
      run = !m_stop[c];
      rs  = 1'b0;
      case (m_src[c])
        3'b001:  sel = p;
        3'b010:  sel = r;
        3'b100:  sel = e;
        default: sel = 1'b0;
      endcase
      n = int'(m_pre[c]);
      if (n > 5) n = 5;
      lim = (1 << (2 * n)) - 1;
      if (we && a == ADDR_W'(8 + c) && (run || g)) begin
        rs = (wd[5:3] != m_pre[c]);
        m_src[c] = wd[2:0];
        m_pre[c] = wd[5:3];
      end
      et[c] = 1'b0;
      if (!run || rs) m_cnt[c] = 0;
      else if (sel) begin
        if (m_cnt[c] == lim) begin m_cnt[c] = 0; et[c] = 1'b1; end
        else m_cnt[c] = m_cnt[c] + 1;
      end
    end
    for (int c = 0; c < NCH; c++) begin
      if (we && a == ADDR_W'(1) && wd[bit_of(c)]) m_stop[c] = 1'b1;
      if (we && a == ADDR_W'(2) && wd[bit_of(c)]) m_stop[c] = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    total++;
    if (chan_tick !== et) begin
      bad++;
      $display("FAIL %s tick got=%h exp=%h", tag, chan_tick, et);
    end
    if (!we) begin
      total++;
      if (reg_rdata !== er) begin
        bad++;
        $display("FAIL %s rdata addr=%0d got=%h exp=%h", tag, a, reg_rdata, er);
      end
    end
    for (int c = 0; c < NCH; c++) obs[c] += int'(chan_tick[c]);
  endtask

  task automatic wr(int a, logic [31:0] d, string tag);
    cyc(1'b1, ADDR_W'(a), d, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic wrg(int a, logic [31:0] d, string tag);
    cyc(1'b1, ADDR_W'(a), d, 1'b0, 1'b0, 1'b0, 1'b1, tag);
  endtask

  task automatic idle(int n, logic p, logic r, logic e, string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, '0, p, r, e, 1'b0, tag);
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    cyc(1'b0, ADDR_W'(a), '0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    total++;
    if (reg_rdata !== exp) begin
      bad++;
      $display("FAIL %s read addr=%0d got=%h exp=%h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic clr_obs();
    for (int c = 0; c < NCH; c++) obs[c] = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [2:0]  srcs [8];
    int          k;
    srcs = '{3'b001, 3'b010, 3'b100, 3'b001, 3'b010, 3'b100, 3'b000, 3'b011};
    for (int c = 0; c < NCH; c++) begin
      m_stop[c] = 1'b1; m_src[c] = '0; m_pre[c] = '0; m_cnt[c] = 0; obs[c] = 0;
    end
    void'($urandom(32'd4242));
    rst_n = 1'b0; unit_clk_en = 1'b0; reg_addr = '0; reg_we = 1'b0;
    reg_wdata = '0; src_pclk_stb = 1'b0; src_rtc_stb = 1'b0; src_ext_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_eq("R1 tick", int'(chan_tick), 0);
    rd(0, 32'h0001_80FF, "R1");
    for (int c = 0; c < NCH; c++) rd(8 + c, 32'h0, "R1");

    // R4 strobe registers and unmapped read zero
    rd(1, 32'h0, "R4");
    rd(2, 32'h0, "R4");
    rd(4, 32'h0, "R4");

    // R2 clear-stop
    wr(2, 32'h0000_0005, "R2"); rd(0, 32'h0001_80FA, "R2");
    wr(2, 32'h0, "R2");         rd(0, 32'h0001_80FA, "R2");
    // R4 positions of OS timer and watchdog
    wr(2, 32'h0000_8000, "R4"); rd(0, 32'h0001_00FA, "R4");
    wr(2, 32'h0001_0000, "R4"); rd(0, 32'h0000_00FA, "R4");
    wr(1, 32'h0001_0000, "R4"); rd(0, 32'h0001_00FA, "R4");
    // R3 set-stop
    wr(1, 32'h0000_0004, "R3"); rd(0, 32'h0001_00FE, "R3");
    wr(1, 32'h0, "R3");         rd(0, 32'h0001_00FE, "R3");

    // R5 control layout, upper bits ignored
    wr(8, 32'hFFFF_FFC1, "R5"); rd(8, 32'h0000_0001, "R5");
    clr_obs(); idle(5, 1'b1, 1'b0, 1'b0, "R6");
    check_eq("R6 div1 ticks", obs[0], 5);
    check_eq("R8 zero src ticks", obs[8], 0);
    wr(8, 32'h2, "R5");
    clr_obs(); idle(6, 1'b1, 1'b0, 1'b1, "R5");
    check_eq("R5 rtc ignores others", obs[0], 0);
    idle(6, 1'b0, 1'b1, 1'b0, "R5");
    check_eq("R5 rtc ticks", obs[0], 6);
    wr(8, 32'h4, "R5");
    clr_obs(); idle(4, 1'b0, 1'b0, 1'b1, "R5");
    check_eq("R5 ext ticks", obs[0], 4);

    // R6 OS timer index, watchdog stays stopped
    wr(16, 32'h1, "R6");
    clr_obs(); idle(3, 1'b1, 1'b0, 1'b0, "R6");
    check_eq("R6 os ticks", obs[8], 3);
    check_eq("R3 wdt stopped", obs[9], 0);

    // R7 write lock on stopped channel
    wr(9, 32'h0A, "R7");  rd(9, 32'h0, "R7");
    wrg(9, 32'h0A, "R7"); rd(9, 32'h0A, "R7");

    // R8 invalid source codes
    foreach (srcs[i]) if (i >= 6) begin
      wr(8, {29'h0, srcs[i]}, "R8");
      clr_obs(); idle(20, 1'b1, 1'b1, 1'b1, "R8");
      check_eq("R8 bad src ticks", obs[0], 0);
    end

    // R6 prescale sweep including saturating codes
    for (int n = 0; n < 8; n++) begin
      wr(8, {26'h0, 3'(n), 3'b001}, "R6");
      clr_obs(); idle(2048, 1'b1, 1'b0, 1'b0, "R6");
      check_eq("R6 sweep ticks", obs[0], 2048 >> (2 * ((n > 5) ? 5 : n)));
    end

    // R9 restart on prescale change, drop same-cycle strobe
    wr(8, 32'h11, "R9");
    clr_obs(); idle(10, 1'b1, 1'b0, 1'b0, "R9");
    check_eq("R9 partial", obs[0], 0);
    cyc(1'b1, ADDR_W'(8), 32'h09, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
    idle(3, 1'b1, 1'b0, 1'b0, "R9");
    check_eq("R9 after restart 3", obs[0], 0);
    idle(1, 1'b1, 1'b0, 1'b0, "R9");
    check_eq("R9 after restart 4", obs[0], 1);
    idle(2, 1'b1, 1'b0, 1'b0, "R9");
    wr(8, 32'h09, "R9");
    idle(2, 1'b1, 1'b0, 1'b0, "R9");
    check_eq("R9 same pre keeps count", obs[0], 2);

    // R10 stop clears the count
    clr_obs(); idle(2, 1'b1, 1'b0, 1'b0, "R10");
    wr(1, 32'h1, "R10");
    idle(5, 1'b1, 1'b0, 1'b0, "R3");
    check_eq("R3 stopped no ticks", obs[0], 0);
    wr(2, 32'h1, "R10");
    idle(3, 1'b1, 1'b0, 1'b0, "R10");
    check_eq("R10 fresh count 3", obs[0], 0);
    idle(1, 1'b1, 1'b0, 1'b0, "R10");
    check_eq("R10 fresh count 4", obs[0], 1);

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      logic              we;
      logic [ADDR_W-1:0] a;
      k = int'($urandom_range(0, 9));
      we = 1'b1; d = $urandom;
      if (k < 3) begin
        a = ADDR_W'(8 + int'($urandom_range(0, NCH - 1)));
        d[2:0] = srcs[$urandom_range(0, 7)];
        d[5:3] = 3'($urandom_range(0, 3));
      end else if (k == 3) begin
        a = ADDR_W'(1); d = $urandom & $urandom & $urandom;
      end else if (k == 4) begin
        a = ADDR_W'(2);
      end else begin
        we = 1'b0; a = ADDR_W'($urandom_range(0, 31));
      end
      cyc(we, a, d, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 7) == 0), "R6");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule